// File: doc/BRIEF.md
# Strided Interleaved Vector Memory Controller

This block carries out one vector load or vector store at a time against a word-addressed memory that is split into sixteen interleaved banks. A command gives a start address, a two's-complement stride and an element count. The block walks the element addresses in order and sends at most one element to memory per clock. Each bank keeps its own busy timer. When the bank of the next element is still busy, the walk waits. It never skips ahead to a later element.

For a store, the block shows the index of the element it is about to send. The surrounding logic presents that element's data on the store-data input in the same cycle. For a load, each word comes back a fixed number of cycles after its access. It appears on the load port together with its element index, in element order. A one-cycle done pulse marks the end of each command. The next command is accepted only when the block is idle.

Since the bank is taken from the low address bits, the stride sets the sustained rate. A stride that shares no factor with sixteen reaches every bank before it returns to one, so it runs at one element per clock. Large power-of-two strides keep returning to the same few banks and must wait on the busy timers.

Top module: `vec_stride_mem`

## Requirements
- R1: The bank of a word address is its low four bits (address mod 16). Suppose a bank is accessed in cycle c. It cannot be accessed in cycles c+1, c+2 or c+3, and it can be accessed again from cycle c+4.
- R2: Element i uses word address base + i*stride. The stride is two's complement and the sum wraps modulo 2^AW, so negative strides and address wrap-around work.
- R3: Elements are issued strictly in index order, at most one per cycle. `elem_go` is high in the cycle an element is sent, and `elem_idx` holds that element's index. If the next element's bank is busy, `elem_go` stays low until the bank is free.
- R4: A load element issued in cycle c appears in cycle c+12 with `ld_valid` high, its index on `ld_idx` and the memory word on `ld_data`. For a unit-stride load on idle banks, the first word therefore appears 13 cycles after the accept cycle.
- R5: A store element issued in cycle c writes the value on `st_data` during cycle c into its address. A later load of that address returns the value.
- R6: `done` is high for exactly one cycle. For a load, it comes in the cycle after the last word appears on the load port. For a store, it comes in the cycle after the last element is issued. With a length of 0, it comes in the cycle after the accept cycle and no element is issued.
- R7: A command is accepted in a cycle where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is high only while no command is running. A command offered while one is running is ignored and changes neither that command's outputs nor its timing.
- R8: Consider a load on idle banks, with a accept-to-done count measured from the accept cycle to the done cycle. Strides 1, 2 and 3 issue one element per cycle: 16 elements at stride 1 give 29 cycles, 32 at stride 2 give 45, and 21 at stride 3 give 34. Stride 8 issues two elements every four cycles, so 8 elements give 27. Stride 16 issues one element every four cycles, so 4 elements give 26.
- R9: During reset, and just after it, `cmd_ready` is 1 and `elem_go`, `ld_valid` and `done` are 0. All bank timers start free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_store | input | 1 | 1 = store, 0 = load |
| cmd_base | input | AW | First element word address |
| cmd_stride | input | AW | Signed word stride |
| cmd_len | input | LW | Element count, 0 to MAXLEN |
| cmd_ready | output | 1 | Idle, a command can be accepted |
| st_data | input | DW | Store data for element `elem_idx` |
| elem_go | output | 1 | An element is sent to its bank this cycle |
| elem_idx | output | LW | Index of the next or current element |
| ld_valid | output | 1 | Load word present |
| ld_idx | output | LW | Element index of the load word |
| ld_data | output | DW | Load word |
| done | output | 1 | Command finished, one-cycle pulse |

## Verification
The bench goes after the stride-dependent bank conflicts. A busy window that is one cycle short or long shows up as a wrong accept-to-done count at stride 8 or 16. A design that reorders elements past a conflict puts indices out of order on the load port. The bench also covers a load right after a same-bank store, where the earlier command's timers still stall the new one. A design that clears timers between commands issues that load one cycle early. Negative strides and wrap-around past the top address are included, because an address adder that does not sign-extend or wrap reads the wrong words. The bench also offers a length of zero, which a design with an off-by-one counter turns into a stray access, and a command offered while another is running, which would corrupt the running one if taken.

// File: rtl/vec_stride_mem.sv
module vec_stride_mem #(
  parameter int AW     = 10,
  parameter int DW     = 32,
  parameter int NBANK  = 16,
  parameter int BUSY   = 4,
  parameter int RD_LAT = 12,
  parameter int MAXLEN = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic          cmd_store,
  input  logic [AW-1:0] cmd_base,
  input  logic [AW-1:0] cmd_stride,
  input  logic [$clog2(MAXLEN+1)-1:0] cmd_len,
  output logic          cmd_ready,
  input  logic [DW-1:0] st_data,
  output logic          elem_go,
  output logic [$clog2(MAXLEN+1)-1:0] elem_idx,
  output logic          ld_valid,
  output logic [$clog2(MAXLEN+1)-1:0] ld_idx,
  output logic [DW-1:0] ld_data,
  output logic          done
);
  localparam int LW    = $clog2(MAXLEN+1);
  localparam int BW    = $clog2(NBANK);
  localparam int TW    = $clog2(BUSY);
  localparam int WORDS = 1 << AW;

  logic          run_q, store_q;
  logic [AW-1:0] addr_q, stride_q;
  logic [LW-1:0] len_q, cnt_q;
  logic [TW-1:0] timer [NBANK];
  logic [RD_LAT-1:0] pv;
  logic [LW-1:0] pi [RD_LAT];
  logic [DW-1:0] pd [RD_LAT];
  logic [DW-1:0] mem [WORDS];

  wire [BW-1:0] bank      = addr_q[BW-1:0];
  wire          bank_free = (timer[bank] == '0);
  wire          accept    = cmd_valid && !run_q;

  assign cmd_ready = !run_q;
  assign elem_go   = run_q && (cnt_q != len_q) && bank_free;
  assign elem_idx  = cnt_q;
  assign done      = run_q && (cnt_q == len_q) && !(|pv);
  assign ld_valid  = pv[RD_LAT-1];
  assign ld_idx    = pi[RD_LAT-1];
  assign ld_data   = pd[RD_LAT-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      store_q  <= 1'b0;
      addr_q   <= '0;
      stride_q <= '0;
      len_q    <= '0;
      cnt_q    <= '0;
    end else if (accept) begin
      run_q    <= 1'b1;
      store_q  <= cmd_store;
      addr_q   <= cmd_base;
      stride_q <= cmd_stride;
      len_q    <= cmd_len;
      cnt_q    <= '0;
    end else if (elem_go) begin
      addr_q <= addr_q + stride_q;
      cnt_q  <= cnt_q + LW'(1);
    end else if (done) begin
      run_q <= 1'b0;
    end
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rst_n)
        timer[b] <= '0;
      else if (elem_go && bank == BW'(b))
        timer[b] <= TW'(BUSY-1);
      else if (timer[b] != '0)
        timer[b] <= timer[b] - TW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (elem_go && store_q)
      mem[addr_q] <= st_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      pv <= '0;
    else
      pv <= {pv[RD_LAT-2:0], elem_go && !store_q};
  end

  always_ff @(posedge clk) begin
    pi[0] <= cnt_q;
    pd[0] <= mem[addr_q];
  end

  for (genvar k = 1; k < RD_LAT; k++) begin : g_pipe
    always_ff @(posedge clk) begin
      pi[k] <= pi[k-1];
      pd[k] <= pd[k-1];
    end
  end

  // the depths below assume BUSY >= 4
  assert_bank_gap1_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (elem_go && $past(elem_go)) |-> (addr_q[BW-1:0] != $past(addr_q[BW-1:0])));
  assert_bank_gap2_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (elem_go && $past(elem_go, 2)) |-> (addr_q[BW-1:0] != $past(addr_q[BW-1:0], 2)));
  assert_bank_gap3_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (elem_go && $past(elem_go, 3)) |-> (addr_q[BW-1:0] != $past(addr_q[BW-1:0], 3)));
  assert_idx_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    elem_go |=> (elem_idx == $past(elem_idx) + LW'(1)));
  assert_idx_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!elem_go && !cmd_ready) |=> $stable(elem_idx));
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && cmd_ready));
  assert_busy_ignore_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_ready |=> ($stable(len_q) && $stable(stride_q) && $stable(store_q)));
  assert_no_go_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !elem_go);
endmodule

// File: tb/vec_stride_mem_test.sv
module vec_stride_mem_test;
  localparam int LW = 7;
  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, cmd_store = 0;
  logic [9:0] cmd_base = 0, cmd_stride = 0;
  logic [LW-1:0] cmd_len = 0;
  logic cmd_ready, elem_go, ld_valid, done;
  logic [LW-1:0] elem_idx, ld_idx;
  logic [31:0] st_data, ld_data, pat = 0;

  always #10 clk = ~clk;

  assign st_data = pat ^ (32'(elem_idx) * 32'h9E3779B1);

  vec_stride_mem uut (.clk, .rst_n, .cmd_valid, .cmd_store, .cmd_base, .cmd_stride,
    .cmd_len, .cmd_ready, .st_data, .elem_go, .elem_idx, .ld_valid, .ld_idx,
    .ld_data, .done);

  int n_chk = 0, n_bad = 0;
  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  // behavioural reference
  int cyc = 0;
  bit m_run = 0, m_store = 0;
  int m_i, m_len, m_addr, m_stride;
  int bfree [16];
  logic [31:0] mm [1024];
  int q_due[$], q_idx[$];
  logic [31:0] q_dat[$];
  int obs_acc, obs_done, obs_first;
  bit first_seen;

  always @(negedge clk) begin
    if (!rst_n) begin
      chk(cmd_ready === 1'b1, "R9 cmd_ready in reset", cmd_ready, 1);
      chk(elem_go === 1'b0 && ld_valid === 1'b0 && done === 1'b0,
          "R9 outputs quiet in reset", {elem_go, ld_valid, done}, 0);
    end else begin
      int b;
      bit e_go, e_ld, e_done;
      b = m_addr & 15;
      e_go = m_run && m_i < m_len && cyc >= bfree[b];
      e_ld = q_due.size() > 0 && q_due[0] == cyc;
      e_done = m_run && m_i == m_len && q_due.size() == 0;
      chk(cmd_ready === !m_run, "R7 cmd_ready", cmd_ready, !m_run);
      chk(elem_go === e_go, "R3 elem_go (R1 bank busy)", elem_go, e_go);
      if (e_go) chk(elem_idx == LW'(m_i), "R3 elem_idx", elem_idx, m_i);
      chk(ld_valid === e_ld, "R4 ld_valid", ld_valid, e_ld);
      if (e_ld) begin
        chk(ld_idx == LW'(q_idx[0]), "R4 ld_idx", ld_idx, q_idx[0]);
        chk(ld_data === q_dat[0], "R2/R5 ld_data", ld_data, q_dat[0]);
      end
      chk(done === e_done, "R6 done", done, e_done);
      if (ld_valid && !first_seen) begin first_seen = 1; obs_first = cyc; end
      if (done) obs_done = cyc;
      if (cmd_valid && cmd_ready) obs_acc = cyc;
      if (e_go) begin
        bfree[b] = cyc + 4;
        if (m_store) mm[m_addr] = pat ^ (32'(m_i) * 32'h9E3779B1);
        else begin q_due.push_back(cyc + 12); q_idx.push_back(m_i); q_dat.push_back(mm[m_addr]); end
        m_i++;
        m_addr = (m_addr + m_stride) & 1023;
      end
      if (e_ld) begin void'(q_due.pop_front()); void'(q_idx.pop_front()); void'(q_dat.pop_front()); end
      if (e_done) m_run = 0;
      else if (!m_run && cmd_valid) begin
        m_run = 1; m_store = cmd_store; m_i = 0; m_len = int'(cmd_len);
        m_addr = int'(cmd_base); m_stride = int'($signed(cmd_stride));
        first_seen = 0;
      end
      cyc++;
    end
  end

  task automatic issue(input bit st, input int base, input int stride, input int len, input logic [31:0] p);
    while (!cmd_ready) begin @(posedge clk); #1; end
    pat = p; cmd_store = st; cmd_base = base[9:0]; cmd_stride = stride[9:0];
    cmd_len = LW'(len); cmd_valid = 1;
    @(posedge clk); #1;
    cmd_valid = 0;
  endtask

  task automatic finish_cmd();
    while (!cmd_ready) begin @(posedge clk); #1; end
  endtask

  task automatic timed(input bit st, input int base, input int stride, input int len, input int exp, input string tag);
    issue(st, base, stride, len, pat);
    finish_cmd();
    chk(obs_done - obs_acc == exp, tag, obs_done - obs_acc, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    foreach (bfree[k]) bfree[k] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(posedge clk); #1;
    issue(1, 0, 1, 64, 32'h1234_5678);
    finish_cmd();
    chk(obs_done - obs_acc == 65, "R6 unit-stride store done timing", obs_done - obs_acc, 65);
    timed(0, 0, 1, 16, 29, "R8 stride 1 load cycles");
    chk(obs_first - obs_acc == 13, "R4 unit-stride startup", obs_first - obs_acc, 13);
    timed(0, 0, 2, 32, 45, "R8 stride 2 load cycles");
    timed(0, 0, 3, 21, 34, "R8 stride 3 load cycles");
    timed(0, 0, 8, 8, 27, "R8 stride 8 load cycles");
    timed(0, 0, 16, 4, 26, "R8 stride 16 load cycles (R1 gap)");
    timed(0, 5, 1, 0, 1, "R6 zero-length load");
    timed(1, 5, 1, 0, 1, "R6 zero-length store");
    // R1: timers carry across back-to-back commands
    issue(1, 0, 16, 4, 32'hCAFE_0001);
    issue(0, 0, 16, 4, 32'h0);
    finish_cmd();
    // R2: negative stride
    issue(1, 63, -1, 20, 32'h0BAD_F00D);
    issue(0, 63, -1, 20, 32'h0);
    issue(0, 44, 1, 20, 32'h0);
    finish_cmd();
    // R2: wrap past the top address
    issue(1, 1020, 3, 8, 32'h7777_AAAA);
    issue(0, 1020, 3, 8, 32'h0);
    issue(0, 2, 3, 6, 32'h0);
    finish_cmd();
    // R7: command offered while busy is ignored
    issue(0, 0, 16, 4, 32'h0);
    repeat (3) @(posedge clk);
    #1 cmd_store = 1; cmd_len = 5; cmd_stride = 1; cmd_valid = 1;
    @(posedge clk); #1 cmd_valid = 0;
    finish_cmd();
    chk(obs_done - obs_acc == 26, "R7 busy command ignored, timing intact", obs_done - obs_acc, 26);
    repeat (4) @(posedge clk);
    chk(m_run == 0 && cmd_ready, "R7 no extra command started", cmd_ready, 1);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule